// File: doc/BRIEF.md
# Dual-Width Integer ALU

This block is the integer execute unit of a 64-bit datapath. It performs addition, subtraction, multiplication, bitwise logic, shifts, rotates, bit counting and compare/set operations on two 64-bit operands. A width-select input picks between a full 64-bit operation and a 32-bit operation. A 32-bit operation reads only the low halves of the operands, wraps inside 32 bits, and zero-extends its result to 64 bits. It never sign-extends.

Each accepted request produces one registered result one clock later, together with a one-cycle valid strobe. A new request can be accepted every cycle. The result register keeps its value until the next request. Division, remainder, memory access and register writeback belong to other blocks.

Top module: `dw_alu`

## Requirements
- R1: While reset is applied, and until the first request after reset, `out_vld` is 0 and `out_res` is 0. Reset is asynchronous and active-low. Its release is synchronized over two clock edges.
- R2: A request with `in_vld`=1 at clock edge N gives `out_vld`=1 and the result on `out_res` after edge N. A cycle with `in_vld`=0 gives `out_vld`=0 after that edge, and `out_res` keeps its previous value. Operands presented while `in_vld` is low have no effect.
- R3: `op_sel` encoding: 0 ADD, 1 SUB, 2 MUL, 3 AND, 4 OR, 5 XOR, 6 SHL, 7 SRA, 8 SRL, 9 ROL, 10 ROR, 11 CLZ, 12 CTZ, 13 POPC, 14 INC, 15 DEC, 16 EQ, 17 NE, 18 LTS, 19 LES, 20 GTS, 21 GES, 22 LTU, 23 LEU, 24 GTU, 25 GEU. `wide`=1 selects 64-bit mode and `wide`=0 selects 32-bit mode. Every operation computes A op B, with A = `opa` and B = `opb`.
- R4: In 32-bit mode, ADD, SUB, MUL, AND, OR and XOR use only bits 31:0 of each operand. The result wraps modulo 2^32, and bits 63:32 of the result are 0.
- R5: In 64-bit mode, the same operations use the full operands and wrap modulo 2^64.
- R6: SHL, SRA, SRL, ROL and ROR shift or rotate A by B modulo the width: B[4:0] in 32-bit mode and B[5:0] in 64-bit mode. In 32-bit mode SRA copies bit 31 of A, and the result is zero-extended.
- R7: CLZ, CTZ and POPC count the leading zeros, trailing zeros and one bits of A within the selected width. CLZ and CTZ of a zero value return 32 or 64, depending on the width.
- R8: INC returns A+1 and DEC returns A-1, always computed on the low 32 bits and zero-extended. `wide` and `opb` have no effect on them.
- R9: Compare operations return 1 when true and 0 when false. LTS, LES, GTS and GES compare as signed; in 32-bit mode the sign is bit 31. LTU, LEU, GTU and GEU compare as unsigned. EQ and NE test equality within the selected width.
- R10: `op_sel` values 26 to 31 return a result of 0, with `out_vld` asserted as usual.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Request strobe |
| op_sel | input | 5 | Operation code (see R3) |
| wide | input | 1 | 1 = 64-bit, 0 = 32-bit |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| out_vld | output | 1 | Result strobe, one cycle after a request |
| out_res | output | 64 | Registered result |

## Verification
The only state in this block is the result register, its valid flag and the reset synchronizer. A fault in any of them shows at the ports one cycle after the request that caused it. That single cycle of visibility lets the scoreboard pin any mismatch to one request.

A wrong width path shows as nonzero upper bits after a 32-bit request, or as a wrong wrap at the 32-bit boundary. A wrong capture enable shows as a changed `out_res` after an idle cycle.

Directed corners cover the wrap points, shift amounts of 32 and above, zero inputs to the counters, and signed compares across bit 31. A long random stream, with idle gaps, covers every code.

// File: rtl/dw_alu_pkg.sv
package dw_alu_pkg;
  localparam int unsigned OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,  OP_SUB  = 5'd1,  OP_MUL  = 5'd2,  OP_AND  = 5'd3,
    OP_OR   = 5'd4,  OP_XOR  = 5'd5,  OP_SHL  = 5'd6,  OP_SRA  = 5'd7,
    OP_SRL  = 5'd8,  OP_ROL  = 5'd9,  OP_ROR  = 5'd10, OP_CLZ  = 5'd11,
    OP_CTZ  = 5'd12, OP_POPC = 5'd13, OP_INC  = 5'd14, OP_DEC  = 5'd15,
    OP_EQ   = 5'd16, OP_NE   = 5'd17, OP_LTS  = 5'd18, OP_LES  = 5'd19,
    OP_GTS  = 5'd20, OP_GES  = 5'd21, OP_LTU  = 5'd22, OP_LEU  = 5'd23,
    OP_GTU  = 5'd24, OP_GEU  = 5'd25
  } alu_op_e;

  typedef enum logic [2:0] {
    CLS_ARITH, CLS_SHIFT, CLS_COUNT, CLS_CMP, CLS_NONE
  } alu_cls_e;

  function automatic alu_cls_e op_class(input logic [OPW-1:0] code);
    if (code <= OP_XOR || code == OP_INC || code == OP_DEC) return CLS_ARITH;
    if (code >= OP_SHL && code <= OP_ROR)                   return CLS_SHIFT;
    if (code >= OP_CLZ && code <= OP_POPC)                  return CLS_COUNT;
    if (code >= OP_EQ && code <= OP_GEU)                    return CLS_CMP;
    return CLS_NONE;
  endfunction
endpackage

// File: rtl/dw_alu_arith.sv
module dw_alu_arith
  import dw_alu_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [OPW-1:0]  op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o
);
  localparam logic [XLEN-1:0] ONE = XLEN'(1);

  always_comb begin
    case (op_i)
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_MUL:  res_o = a_i * b_i;
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_INC:  res_o = a_i + ONE;
      OP_DEC:  res_o = a_i - ONE;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/dw_alu_shift.sv
module dw_alu_shift
  import dw_alu_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [OPW-1:0]          op_i,
  input  logic                    wide_i,
  input  logic [XLEN-1:0]         a_i,
  input  logic [$clog2(XLEN)-1:0] amt_i,
  output logic [XLEN-1:0]         res_o
);
  localparam int unsigned HLEN = XLEN / 2;
  localparam int unsigned SW   = $clog2(XLEN);

  logic [SW-2:0]        amt_n;
  logic [HLEN-1:0]      lo;
  logic [2*XLEN-1:0]    dbl_l, dbl_r;
  logic [2*HLEN-1:0]    dbn_l, dbn_r;
  logic [XLEN-1:0]      wres;
  logic [HLEN-1:0]      nres;

  assign amt_n = amt_i[SW-2:0];
  assign lo    = a_i[HLEN-1:0];

  // full-width path
  always_comb begin
    dbl_l = {a_i, a_i} << amt_i;
    dbl_r = {a_i, a_i} >> amt_i;
    case (op_i)
      OP_SHL:  wres = a_i << amt_i;
      OP_SRL:  wres = a_i >> amt_i;
      OP_SRA:  wres = $unsigned($signed(a_i) >>> amt_i);
      OP_ROL:  wres = dbl_l[2*XLEN-1:XLEN];
      OP_ROR:  wres = dbl_r[XLEN-1:0];
      default: wres = '0;
    endcase
  end

  // half-width path, sign taken from bit HLEN-1
  always_comb begin
    dbn_l = {lo, lo} << amt_n;
    dbn_r = {lo, lo} >> amt_n;
    case (op_i)
      OP_SHL:  nres = lo << amt_n;
      OP_SRL:  nres = lo >> amt_n;
      OP_SRA:  nres = $unsigned($signed(lo) >>> amt_n);
      OP_ROL:  nres = dbn_l[2*HLEN-1:HLEN];
      OP_ROR:  nres = dbn_r[HLEN-1:0];
      default: nres = '0;
    endcase
  end

  assign res_o = wide_i ? wres : {{HLEN{1'b0}}, nres};
endmodule

// File: rtl/dw_alu_bitcnt.sv
module dw_alu_bitcnt
  import dw_alu_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [OPW-1:0]            op_i,
  input  logic                      wide_i,
  input  logic [XLEN-1:0]           a_i,
  output logic [$clog2(XLEN):0]     cnt_o
);
  localparam int unsigned HLEN = XLEN / 2;
  localparam int unsigned CW   = $clog2(XLEN) + 1;

  logic [XLEN-1:0] lead_src;
  logic [CW-1:0]   lz, tz, pc, limit;
  logic            hit_l, hit_t;

  // narrow operands are moved to the top so leading zeros start at bit 31
  assign lead_src = wide_i ? a_i : {a_i[HLEN-1:0], {HLEN{1'b0}}};
  assign limit    = wide_i ? CW'(XLEN) : CW'(HLEN);

  always_comb begin
    lz = '0;
    hit_l = 1'b0;
    for (int i = XLEN - 1; i >= 0; i--) begin
      if (!hit_l) begin
        if (lead_src[i]) hit_l = 1'b1;
        else             lz = lz + CW'(1);
      end
    end
  end

  always_comb begin
    tz = '0;
    hit_t = 1'b0;
    for (int i = 0; i < XLEN; i++) begin
      if (!hit_t) begin
        if (a_i[i]) hit_t = 1'b1;
        else        tz = tz + CW'(1);
      end
    end
  end

  always_comb begin
    pc = '0;
    for (int i = 0; i < XLEN; i++) pc = pc + CW'(a_i[i]);
  end

  always_comb begin
    case (op_i)
      OP_CLZ:  cnt_o = (lz > limit) ? limit : lz;
      OP_CTZ:  cnt_o = (tz > limit) ? limit : tz;
      OP_POPC: cnt_o = pc;
      default: cnt_o = '0;
    endcase
  end
endmodule

// File: rtl/dw_alu_cmp.sv
module dw_alu_cmp
  import dw_alu_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [OPW-1:0]  op_i,
  input  logic            wide_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            flag_o
);
  localparam int unsigned HLEN = XLEN / 2;

  logic signed [XLEN-1:0] sa, sb;
  logic                   eq, lt_s, lt_u;

  // operands arrive zero-extended in narrow mode; rebuild signed view
  assign sa   = wide_i ? $signed(a_i) : $signed({{HLEN{a_i[HLEN-1]}}, a_i[HLEN-1:0]});
  assign sb   = wide_i ? $signed(b_i) : $signed({{HLEN{b_i[HLEN-1]}}, b_i[HLEN-1:0]});
  assign eq   = (a_i == b_i);
  assign lt_s = (sa < sb);
  assign lt_u = (a_i < b_i);

  always_comb begin
    case (op_i)
      OP_EQ:   flag_o = eq;
      OP_NE:   flag_o = !eq;
      OP_LTS:  flag_o = lt_s;
      OP_LES:  flag_o = lt_s || eq;
      OP_GTS:  flag_o = !(lt_s || eq);
      OP_GES:  flag_o = !lt_s;
      OP_LTU:  flag_o = lt_u;
      OP_LEU:  flag_o = lt_u || eq;
      OP_GTU:  flag_o = !(lt_u || eq);
      OP_GEU:  flag_o = !lt_u;
      default: flag_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dw_alu.sv
module dw_alu
  import dw_alu_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  input  logic [4:0]      op_sel,
  input  logic            wide,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            out_vld,
  output logic [XLEN-1:0] out_res
);
  localparam int unsigned HLEN = XLEN / 2;
  localparam int unsigned SW   = $clog2(XLEN);
  localparam int unsigned CW   = SW + 1;

  // reset synchronizer: asserts at once, releases after two edges
  logic rst_m, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m     <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_m     <= 1'b1;
      rst_int_n <= rst_m;
    end
  end

  // operand conditioning
  logic            eff_wide;
  logic [XLEN-1:0] a_t, b_t;
  alu_cls_e        cls;

  assign eff_wide = wide && (op_sel != OP_INC) && (op_sel != OP_DEC);
  assign a_t      = eff_wide ? opa : {{HLEN{1'b0}}, opa[HLEN-1:0]};
  assign b_t      = eff_wide ? opb : {{HLEN{1'b0}}, opb[HLEN-1:0]};
  assign cls      = op_class(op_sel);

  logic [XLEN-1:0] r_arith, r_shift;
  logic [CW-1:0]   r_cnt;
  logic            r_flag;

  dw_alu_arith #(.XLEN(XLEN)) u_arith (
    .op_i(op_sel), .a_i(a_t), .b_i(b_t), .res_o(r_arith)
  );

  dw_alu_shift #(.XLEN(XLEN)) u_shift (
    .op_i(op_sel), .wide_i(eff_wide), .a_i(a_t), .amt_i(opb[SW-1:0]),
    .res_o(r_shift)
  );

  dw_alu_bitcnt #(.XLEN(XLEN)) u_cnt (
    .op_i(op_sel), .wide_i(eff_wide), .a_i(a_t), .cnt_o(r_cnt)
  );

  dw_alu_cmp #(.XLEN(XLEN)) u_cmp (
    .op_i(op_sel), .wide_i(eff_wide), .a_i(a_t), .b_i(b_t), .flag_o(r_flag)
  );

  // result select and width fold
  logic [XLEN-1:0] sel_res, fold_res;
  always_comb begin
    case (cls)
      CLS_ARITH: sel_res = r_arith;
      CLS_SHIFT: sel_res = r_shift;
      CLS_COUNT: sel_res = {{(XLEN-CW){1'b0}}, r_cnt};
      CLS_CMP:   sel_res = {{(XLEN-1){1'b0}}, r_flag};
      default:   sel_res = '0;
    endcase
    fold_res = eff_wide ? sel_res : {{HLEN{1'b0}}, sel_res[HLEN-1:0]};
  end

  // next state
  logic            vld_d;
  logic [XLEN-1:0] res_d;
  always_comb begin
    vld_d = in_vld;
    res_d = in_vld ? fold_res : out_res;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_vld <= 1'b0;
      out_res <= '0;
    end else begin
      out_vld <= vld_d;
      out_res <= res_d;
    end
  end

  // R2: a request is answered on the next edge
  p_vld_next_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_vld |=> out_vld);

  // R2: idle cycles drop the strobe and keep the result
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_vld |=> (!out_vld && $stable(out_res)));

  // R4, R8: narrow requests leave the upper half clear
  p_narrow_zext_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_vld && !eff_wide) |=> (out_res[XLEN-1:HLEN] == '0));

  // R9: compares yield a single bit
  p_cmp_bool_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_vld && cls == CLS_CMP) |=> (out_res[XLEN-1:1] == '0));

  // R7: narrow counts never exceed the half width
  p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_vld && cls == CLS_COUNT && !eff_wide) |=> (out_res <= XLEN'(HLEN)));

  // R10: unassigned codes give zero
  p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_vld && cls == CLS_NONE) |=> (out_res == '0));
endmodule

// File: tb/sim_dw_alu.sv
module sim_dw_alu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld;
  logic [4:0]  op_sel;
  logic        wide;
  logic [63:0] opa, opb;
  logic        out_vld;
  logic [63:0] out_res;

  always #5 clk = ~clk;

  dw_alu u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_sel(op_sel), .wide(wide),
    .opa(opa), .opb(opb), .out_vld(out_vld), .out_res(out_res)
  );

  int n_run  = 0;
  int n_fail = 0;
  logic [63:0] q_exp[$];
  string       q_tag[$];
  logic        mon_on = 1'b0;
  logic        seen   = 1'b0;
  logic [63:0] last_res;

  // reference model written from the requirements
  function automatic logic [63:0] model(input logic [4:0] op, input logic w,
                                        input logic [63:0] a, input logic [63:0] b);
    logic [31:0] a3, b3, r3;
    logic [63:0] r6;
    int n;
    a3 = a[31:0];
    b3 = b[31:0];
    r3 = '0;
    r6 = '0;
    if (op == 5'd14) return {32'h0, a3 + 32'd1};
    if (op == 5'd15) return {32'h0, a3 - 32'd1};
    if (op > 5'd25)  return 64'h0;
    if (!w) begin
      n = int'(b3[4:0]);
      case (op)
        5'd0:  r3 = a3 + b3;
        5'd1:  r3 = a3 - b3;
        5'd2:  r3 = a3 * b3;
        5'd3:  r3 = a3 & b3;
        5'd4:  r3 = a3 | b3;
        5'd5:  r3 = a3 ^ b3;
        5'd6:  r3 = a3 << n;
        5'd7:  r3 = $unsigned($signed(a3) >>> n);
        5'd8:  r3 = a3 >> n;
        5'd9:  r3 = (n == 0) ? a3 : ((a3 << n) | (a3 >> (32 - n)));
        5'd10: r3 = (n == 0) ? a3 : ((a3 >> n) | (a3 << (32 - n)));
        5'd11: begin r3 = 32; for (int i = 31; i >= 0; i--) if (a3[i]) begin r3 = 32'(31 - i); break; end end
        5'd12: begin r3 = 32; for (int i = 0; i < 32; i++) if (a3[i]) begin r3 = 32'(i); break; end end
        5'd13: r3 = 32'($countones(a3));
        5'd16: r3 = 32'(a3 == b3);
        5'd17: r3 = 32'(a3 != b3);
        5'd18: r3 = 32'($signed(a3) <  $signed(b3));
        5'd19: r3 = 32'($signed(a3) <= $signed(b3));
        5'd20: r3 = 32'($signed(a3) >  $signed(b3));
        5'd21: r3 = 32'($signed(a3) >= $signed(b3));
        5'd22: r3 = 32'(a3 <  b3);
        5'd23: r3 = 32'(a3 <= b3);
        5'd24: r3 = 32'(a3 >  b3);
        default: r3 = 32'(a3 >= b3);
      endcase
      return {32'h0, r3};
    end
    n = int'(b[5:0]);
    case (op)
      5'd0:  r6 = a + b;
      5'd1:  r6 = a - b;
      5'd2:  r6 = a * b;
      5'd3:  r6 = a & b;
      5'd4:  r6 = a | b;
      5'd5:  r6 = a ^ b;
      5'd6:  r6 = a << n;
      5'd7:  r6 = $unsigned($signed(a) >>> n);
      5'd8:  r6 = a >> n;
      5'd9:  r6 = (n == 0) ? a : ((a << n) | (a >> (64 - n)));
      5'd10: r6 = (n == 0) ? a : ((a >> n) | (a << (64 - n)));
      5'd11: begin r6 = 64; for (int i = 63; i >= 0; i--) if (a[i]) begin r6 = 64'(63 - i); break; end end
      5'd12: begin r6 = 64; for (int i = 0; i < 64; i++) if (a[i]) begin r6 = 64'(i); break; end end
      5'd13: r6 = 64'($countones(a));
      5'd16: r6 = 64'(a == b);
      5'd17: r6 = 64'(a != b);
      5'd18: r6 = 64'($signed(a) <  $signed(b));
      5'd19: r6 = 64'($signed(a) <= $signed(b));
      5'd20: r6 = 64'($signed(a) >  $signed(b));
      5'd21: r6 = 64'($signed(a) >= $signed(b));
      5'd22: r6 = 64'(a <  b);
      5'd23: r6 = 64'(a <= b);
      5'd24: r6 = 64'(a >  b);
      default: r6 = 64'(a >= b);
    endcase
    return r6;
  endfunction

  function automatic string tag_of(input logic [4:0] op, input logic w);
    if (op <= 5'd5)  return w ? "R5" : "R4";
    if (op <= 5'd10) return "R6";
    if (op <= 5'd13) return "R7";
    if (op <= 5'd15) return "R8";
    if (op <= 5'd25) return "R9";
    return "R10";
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [4:0] op, input logic w, input logic [63:0] a,
                      input logic [63:0] b, input string req);
    @(negedge clk);
    in_vld = 1'b1; op_sel = op; wide = w; opa = a; opb = b;
    q_exp.push_back(model(op, w, a, b));
    q_tag.push_back(req);
  endtask

  task automatic idle(input int cycles);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      in_vld = 1'b0;
      op_sel = 5'($urandom); wide = 1'($urandom);
      opa = {$urandom, $urandom}; opb = {$urandom, $urandom};
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_vld) begin
        if (q_exp.size() == 0) begin
          check("R2 unexpected strobe", 64'h1, 64'h0);
        end else begin
          logic [63:0] e;
          string t;
          e = q_exp.pop_front();
          t = q_tag.pop_front();
          check(t, out_res, e);
        end
        last_res = out_res;
        seen = 1'b1;
      end else if (seen) begin
        check("R2 hold while idle", out_res, last_res);
      end
    end
  end

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; op_sel = '0; wide = 1'b0; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    check("R1 out_vld in reset", {63'h0, out_vld}, 64'h0);
    check("R1 out_res in reset", out_res, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 out_vld after release", {63'h0, out_vld}, 64'h0);
    check("R1 out_res after release", out_res, 64'h0);
    mon_on = 1'b1;

    // R3: every code once with fixed operands, both widths
    for (int c = 0; c < 26; c++) begin
      send(5'(c), 1'b1, 64'hF0F0_1234_8000_0003, 64'h0000_0001_0000_0005, "R3");
      send(5'(c), 1'b0, 64'hF0F0_1234_8000_0003, 64'h0000_0001_0000_0005, "R3");
    end

    // R4: wrap at 32 bits, upper garbage ignored
    send(5'd0, 1'b0, 64'hDEAD_BEEF_FFFF_FFFF, 64'h1234_5678_0000_0001, "R4");
    send(5'd1, 1'b0, 64'hAAAA_AAAA_0000_0000, 64'h0000_0000_0000_0001, "R4");
    send(5'd2, 1'b0, 64'h0000_0000_8000_0001, 64'h0000_0000_0000_0003, "R4");
    // R5: full width wrap
    send(5'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, "R5");
    send(5'd2, 1'b1, 64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000, "R5");
    // R6: amount modulo width, narrow SRA sign from bit 31
    send(5'd6, 1'b0, 64'h1, 64'd33, "R6");
    send(5'd7, 1'b0, 64'h0000_0000_8000_0000, 64'd4, "R6");
    send(5'd9, 1'b1, 64'h8000_0000_0000_0001, 64'd64, "R6");
    send(5'd10, 1'b0, 64'hFFFF_0000_0000_0001, 64'd1, "R6");
    send(5'd7, 1'b1, 64'h8000_0000_0000_0000, 64'd63, "R6");
    // R7: zero inputs return the width
    send(5'd11, 1'b0, 64'hFFFF_FFFF_0000_0000, 64'h0, "R7");
    send(5'd11, 1'b1, 64'h0, 64'h0, "R7");
    send(5'd12, 1'b0, 64'h0, 64'h0, "R7");
    send(5'd12, 1'b1, 64'h8000_0000_0000_0000, 64'h0, "R7");
    send(5'd13, 1'b0, 64'hFFFF_FFFF_0000_000F, 64'h0, "R7");
    // R8: INC/DEC ignore wide
    send(5'd14, 1'b1, 64'h0000_0000_FFFF_FFFF, 64'h55, "R8");
    send(5'd15, 1'b1, 64'h1234_0000_0000_0000, 64'h55, "R8");
    // R9: signed/unsigned across bit 31
    send(5'd18, 1'b0, 64'h0000_0000_8000_0000, 64'h1, "R9");
    send(5'd22, 1'b0, 64'h0000_0000_8000_0000, 64'h1, "R9");
    send(5'd16, 1'b0, 64'h1111_1111_0000_0007, 64'h2222_2222_0000_0007, "R9");
    send(5'd16, 1'b1, 64'h1111_1111_0000_0007, 64'h2222_2222_0000_0007, "R9");
    // R10: unassigned codes
    send(5'd26, 1'b1, 64'h5, 64'h6, "R10");
    send(5'd31, 1'b0, 64'h5, 64'h6, "R10");
    // R2: idle gap, operands wiggle with in_vld low
    idle(3);
    send(5'd0, 1'b1, 64'h10, 64'h20, "R2");
    idle(2);

    // random stream
    for (int k = 0; k < 600; k++) begin
      logic [4:0]  rop;
      logic        rw;
      logic [63:0] ra, rb;
      rop = 5'($urandom);
      rw  = 1'($urandom);
      ra  = {$urandom, $urandom};
      rb  = {$urandom, $urandom};
      if ($urandom_range(0, 7) == 0) ra = '0;
      if ($urandom_range(0, 7) == 0) rb = ra;
      send(rop, rw, ra, rb, tag_of(rop, rw));
      if ($urandom_range(0, 4) == 0) idle(1);
    end
    idle(3);
    check("R2 queue drained", 64'(q_exp.size()), 64'h0);

    summary();
    $finish;
  end
endmodule